// File: doc/BRIEF.md
# Refill Data Wait-and-Replay Controller

This block sits in stage 2 of a data-cache pipeline. The miss queue sends a refill request into the pipeline early, as soon as the next-level cache hints that the line is coming. The refill data only reaches the request in stage 2, where it is forwarded from the miss entry that owns the miss, so it can still be missing when the request gets there. The controller watches the forwarded-data valid flag. It can hold stage 2 for one extra cycle while it waits for the data. If the data has still not come after that cycle, it sends a one-cycle replay pulse to the owning miss entry and squashes the request.

A second replay path covers the case where the chosen victim line still belongs to another active miss entry that is waiting for its acquire response. That line must not be replaced, so the refill is replayed at once. Requests that advance are captured in a stage-3 register. From there, a completed refill returns a refill-done response carrying its miss-entry id, and it raises a writeback request when the victim it replaced was valid. A squashed request leaves no trace in stage 3.

The control is a two-state machine. IDLE means no hold is in progress. WAIT means the request in stage 2 is in its single grace cycle. These are the transitions:
- START_WAIT goes from IDLE to WAIT. It is taken for a valid refill with no forwarded data and no victim conflict.
- RESOLVE goes from WAIT back to IDLE. It is taken unconditionally, whether the request advances, is replayed, or is flushed.
- STAY keeps IDLE in IDLE for every other case.

Top module: `refill_wait_replay`

## Requirements
- R1: While reset is asserted, and in the first cycle after it with stage 2 empty, hold, replay, advance, replay vector, stage-3 update, refill-done and writeback outputs are all 0.
- R2: A valid non-refill request in stage 2 (s2_refill_i = 0) raises advance in the same cycle and is never held or replayed, whatever the data-valid and victim-busy inputs are.
- R3: A valid refill with forwarded data valid and victim not busy raises advance in the same cycle, with no hold.
- R4: A valid refill in IDLE with forwarded data invalid and victim not busy raises hold (advance 0, replay 0) and enters WAIT.
- R5: In WAIT, if the forwarded data is valid and the victim is not busy, the request advances in that cycle with no replay.
- R6: In WAIT, if the forwarded data is still invalid, replay is raised for exactly that cycle and advance and hold stay 0.
- R7: A valid refill whose victim is busy raises replay in the same cycle, in IDLE or in WAIT, even when the forwarded data is valid. It is never held first.
- R8: During replay, replay_id_o equals s2_id_i and replay_vec_o has only bit s2_id_i set (bit i stands for miss entry i). At all other times replay_vec_o is 0.
- R9: In the cycle after a replay, and after a hold, stage 3 shows no update, no refill-done and no writeback.
- R10: In the cycle after a refill advances, refill_done_o is 1 with refill_done_id_o equal to that request's id, s3_update_o is 1, and wb_req_o equals the victim-valid input sampled at the advance.
- R11: In the cycle after a non-refill advances, s3_update_o is 1 and refill_done_o and wb_req_o are 0.
- R12: Hold never lasts two consecutive cycles. Leaving WAIT always returns to IDLE, including when stage 2 is flushed (s2_valid_i = 0) or on reset, so the next refill without data is held again and not replayed.
- R13: At most one of hold, replay and advance is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s2_valid_i | input | 1 | Stage 2 holds a request |
| s2_refill_i | input | 1 | The stage-2 request is a refill |
| s2_id_i | input | ID_W (4) | Owning miss-entry id of the stage-2 request |
| fwd_data_valid_i | input | 1 | Forwarded refill data is valid this cycle |
| victim_busy_i | input | 1 | Victim line is held by another active miss entry |
| victim_valid_i | input | 1 | Victim line is valid and needs a writeback |
| s2_hold_o | output | 1 | Stall stage 2 for this cycle |
| s2_advance_o | output | 1 | Stage-2 request moves to stage 3 at the next edge |
| replay_o | output | 1 | Replay pulse; the request is squashed |
| replay_id_o | output | ID_W (4) | Miss entry that must resend its refill |
| replay_vec_o | output | MSHR_NUM (16) | One-hot replay pulse per miss entry |
| s3_update_o | output | 1 | Stage 3 performs its data/meta update |
| refill_done_o | output | 1 | Refill-done response to the miss queue |
| refill_done_id_o | output | ID_W (4) | Miss-entry id of the completed refill |
| wb_req_o | output | 1 | Victim writeback request to the writeback queue |

## Verification
Hold, replay, replay id, replay vector and advance are combinational. They respond in the same cycle as the stage-2 inputs and the current wait state. The bench drives inputs at the falling edge and samples these outputs shortly after, before the next rising edge. The stage-3 outputs reflect the request that advanced one rising edge earlier. For that reason, each row of the vector table lists the stage-3 values the previous row should produce, and they are checked in the same half-cycle window. The multi-cycle cases are laid out as consecutive rows or as directed steps with one clock edge between them: hold then data, hold then replay, flush during a hold, and reset during a hold.

// File: rtl/rwr_pkg.sv
package rwr_pkg;

    // Wait-state encoding: a single bit of grace per request.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } wait_state_t;

    // Stage-3 side effects per advanced request.
    typedef struct packed {
        logic vld;
        logic refill;
        logic victim_vld;
    } s3_flags_t;

endpackage

// File: rtl/rwr_wait_fsm.sv
module rwr_wait_fsm
    import rwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s2_valid_i,
    input  logic s2_refill_i,
    input  logic fwd_valid_i,
    input  logic victim_busy_i,
    output logic hold_o,
    output logic replay_o,
    output logic advance_o
);

    wait_state_t state_q;
    wait_state_t state_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Transitions: START_WAIT, RESOLVE, STAY
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (s2_valid_i && s2_refill_i && !victim_busy_i && !fwd_valid_i) begin
                    state_n = ST_WAIT;
                end
            end
            ST_WAIT: begin
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        hold_o    = 1'b0;
        replay_o  = 1'b0;
        advance_o = 1'b0;
        if (s2_valid_i) begin
            if (!s2_refill_i) begin
                advance_o = 1'b1;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (victim_busy_i) begin
                            replay_o = 1'b1;
                        end else if (fwd_valid_i) begin
                            advance_o = 1'b1;
                        end else begin
                            hold_o = 1'b1;
                        end
                    end
                    ST_WAIT: begin
                        if (victim_busy_i) begin
                            replay_o = 1'b1;
                        end else if (fwd_valid_i) begin
                            advance_o = 1'b1;
                        end else begin
                            replay_o = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_HOLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> !hold_o); // R12

    AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({hold_o, replay_o, advance_o}) <= 1); // R13

    AST_NONREFILL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid_i && !s2_refill_i) |-> (advance_o && !hold_o && !replay_o)); // R2

    AST_BUSY_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid_i && s2_refill_i && victim_busy_i) |-> replay_o); // R7

    AST_HOLD_RESOLVES: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && s2_valid_i) |=> (!s2_valid_i || replay_o || advance_o)); // R6

endmodule

// File: rtl/rwr_replay_decode.sv
module rwr_replay_decode #(
    parameter int MSHR_NUM = 16,
    parameter int ID_W     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                replay_i,
    input  logic [ID_W-1:0]     id_i,
    output logic [ID_W-1:0]     replay_id_o,
    output logic [MSHR_NUM-1:0] replay_vec_o
);

    assign replay_id_o = replay_i ? id_i : '0;

    for (genvar g = 0; g < MSHR_NUM; g++) begin : g_entry
        assign replay_vec_o[g] = replay_i && (id_i == ID_W'(g));
    end

    AST_VEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(replay_vec_o)); // R8

    AST_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !replay_i |-> (replay_vec_o == '0)); // R8

endmodule

// File: rtl/rwr_s3_stage.sv
module rwr_s3_stage
    import rwr_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance_i,
    input  logic            refill_i,
    input  logic            victim_valid_i,
    input  logic [ID_W-1:0] id_i,
    output logic            update_o,
    output logic            done_o,
    output logic [ID_W-1:0] done_id_o,
    output logic            wb_o
);

    s3_flags_t       flags_q;
    logic [ID_W-1:0] id_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            id_q    <= '0;
        end else begin
            flags_q.vld        <= advance_i;
            flags_q.refill     <= advance_i && refill_i;
            flags_q.victim_vld <= advance_i && refill_i && victim_valid_i;
            if (advance_i) begin
                id_q <= id_i;
            end
        end
    end

    always_comb begin
        update_o  = flags_q.vld;
        done_o    = flags_q.vld && flags_q.refill;
        done_id_o = id_q;
        wb_o      = flags_q.vld && flags_q.refill && flags_q.victim_vld;
    end

    AST_DONE_AFTER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && refill_i) |=> (done_o && done_id_o == $past(id_i))); // R10

    AST_WB_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_o |-> done_o); // R10

endmodule

// File: rtl/refill_wait_replay.sv
module refill_wait_replay
    import rwr_pkg::*;
#(
    parameter int MSHR_NUM = 16,
    localparam int ID_W    = (MSHR_NUM > 1) ? $clog2(MSHR_NUM) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s2_valid_i,
    input  logic                s2_refill_i,
    input  logic [ID_W-1:0]     s2_id_i,
    input  logic                fwd_data_valid_i,
    input  logic                victim_busy_i,
    input  logic                victim_valid_i,
    output logic                s2_hold_o,
    output logic                s2_advance_o,
    output logic                replay_o,
    output logic [ID_W-1:0]     replay_id_o,
    output logic [MSHR_NUM-1:0] replay_vec_o,
    output logic                s3_update_o,
    output logic                refill_done_o,
    output logic [ID_W-1:0]     refill_done_id_o,
    output logic                wb_req_o
);

    logic hold_w;
    logic replay_w;
    logic adv_w;

    rwr_wait_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .s2_valid_i   (s2_valid_i),
        .s2_refill_i  (s2_refill_i),
        .fwd_valid_i  (fwd_data_valid_i),
        .victim_busy_i(victim_busy_i),
        .hold_o       (hold_w),
        .replay_o     (replay_w),
        .advance_o    (adv_w)
    );

    rwr_replay_decode #(
        .MSHR_NUM(MSHR_NUM),
        .ID_W    (ID_W)
    ) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .replay_i    (replay_w),
        .id_i        (s2_id_i),
        .replay_id_o (replay_id_o),
        .replay_vec_o(replay_vec_o)
    );

    rwr_s3_stage #(
        .ID_W(ID_W)
    ) u_s3 (
        .clk           (clk),
        .rst_n         (rst_n),
        .advance_i     (adv_w),
        .refill_i      (s2_refill_i),
        .victim_valid_i(victim_valid_i),
        .id_i          (s2_id_i),
        .update_o      (s3_update_o),
        .done_o        (refill_done_o),
        .done_id_o     (refill_done_id_o),
        .wb_o          (wb_req_o)
    );

    assign s2_hold_o    = hold_w;
    assign s2_advance_o = adv_w;
    assign replay_o     = replay_w;

    AST_REPLAY_NO_S3: assert property (@(posedge clk) disable iff (!rst_n)
        replay_o |=> (!s3_update_o && !refill_done_o && !wb_req_o)); // R9

    AST_HOLD_NO_S3: assert property (@(posedge clk) disable iff (!rst_n)
        s2_hold_o |=> !s3_update_o); // R9

    AST_NONREFILL_S3: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_advance_o && !s2_refill_i) |=> (s3_update_o && !refill_done_o && !wb_req_o)); // R11

endmodule

// File: tb/tb_refill_wait_replay.sv
module tb_refill_wait_replay;

    localparam int MSHR_NUM = 16;
    localparam int ID_W     = 4;
    localparam int NV       = 17;

    // row: [14:10] {valid,refill,fwd,vbusy,vvalid} [9:6] id
    //      [5:3] exp {hold,replay,adv} [2:0] exp prev-row s3 {upd,done,wb}
    localparam logic [14:0] VEC [NV] = '{
        {5'b00000, 4'd0,  3'b000, 3'b000},
        {5'b10000, 4'd3,  3'b001, 3'b000},
        {5'b11101, 4'd5,  3'b001, 3'b100},
        {5'b11000, 4'd7,  3'b100, 3'b111},
        {5'b11100, 4'd7,  3'b001, 3'b000},
        {5'b11001, 4'd2,  3'b100, 3'b110},
        {5'b11001, 4'd2,  3'b010, 3'b000},
        {5'b00000, 4'd0,  3'b000, 3'b000},
        {5'b11111, 4'd9,  3'b010, 3'b000},
        {5'b11000, 4'd4,  3'b100, 3'b000},
        {5'b11110, 4'd4,  3'b010, 3'b000},
        {5'b10010, 4'd6,  3'b001, 3'b000},
        {5'b11000, 4'd1,  3'b100, 3'b100},
        {5'b00000, 4'd1,  3'b000, 3'b000},
        {5'b11000, 4'd1,  3'b100, 3'b000},
        {5'b11100, 4'd1,  3'b001, 3'b000},
        {5'b00000, 4'd0,  3'b000, 3'b110}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s2_valid_i = 1'b0;
    logic s2_refill_i = 1'b0;
    logic [ID_W-1:0] s2_id_i = '0;
    logic fwd_data_valid_i = 1'b0;
    logic victim_busy_i = 1'b0;
    logic victim_valid_i = 1'b0;
    logic s2_hold_o, s2_advance_o, replay_o;
    logic [ID_W-1:0] replay_id_o, refill_done_id_o;
    logic [MSHR_NUM-1:0] replay_vec_o;
    logic s3_update_o, refill_done_o, wb_req_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [ID_W-1:0] last_id = '0;

    always #5 clk = ~clk;

    refill_wait_replay #(.MSHR_NUM(MSHR_NUM)) dut (
        .clk(clk), .rst_n(rst_n),
        .s2_valid_i(s2_valid_i), .s2_refill_i(s2_refill_i), .s2_id_i(s2_id_i),
        .fwd_data_valid_i(fwd_data_valid_i), .victim_busy_i(victim_busy_i),
        .victim_valid_i(victim_valid_i),
        .s2_hold_o(s2_hold_o), .s2_advance_o(s2_advance_o), .replay_o(replay_o),
        .replay_id_o(replay_id_o), .replay_vec_o(replay_vec_o),
        .s3_update_o(s3_update_o), .refill_done_o(refill_done_o),
        .refill_done_id_o(refill_done_id_o), .wb_req_o(wb_req_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string row_tag(input int k);
        case (k)
            0: return "R1";
            1, 11: return "R2";
            2: return "R3";
            3, 5, 12: return "R4";
            4, 15: return "R5";
            6: return "R6";
            7, 9: return "R9";
            8, 10: return "R7";
            13, 14: return "R12";
            default: return "R10";
        endcase
    endfunction

    task automatic drive(input logic [4:0] f, input logic [ID_W-1:0] id);
        {s2_valid_i, s2_refill_i, fwd_data_valid_i, victim_busy_i, victim_valid_i} = f;
        s2_id_i = id;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        #1;
        check("R1", "hold in reset", 32'(s2_hold_o), 0);
        check("R1", "replay in reset", 32'(replay_o), 0);
        check("R1", "adv in reset", 32'(s2_advance_o), 0);
        check("R1", "vec in reset", 32'(replay_vec_o), 0);
        check("R1", "s3 in reset", 32'({s3_update_o, refill_done_o, wb_req_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            logic [14:0] v;
            string t;
            v = VEC[k];
            t = row_tag(k);
            @(negedge clk);
            drive(v[14:10], v[9:6]);
            #1;
            check(t, "hold/replay/adv", 32'({s2_hold_o, replay_o, s2_advance_o}), 32'(v[5:3]));
            check("R13", "one decision", 32'($countones({s2_hold_o, replay_o, s2_advance_o}) <= 1), 1);
            check(v[1] ? "R10" : (v[2] ? "R11" : "R9"), "s3 upd/done/wb",
                  32'({s3_update_o, refill_done_o, wb_req_o}), 32'(v[2:0]));
            if (v[1]) check("R10", "done id", 32'(refill_done_id_o), 32'(last_id));
            if (v[4]) begin
                check("R8", "replay id", 32'(replay_id_o), 32'(v[9:6]));
                check("R8", "replay vec", 32'(replay_vec_o), 32'(1) << v[9:6]);
            end else begin
                check("R8", "vec idle", 32'(replay_vec_o), 0);
            end
            if (v[3]) last_id = v[9:6];
        end

        // R12: reset during WAIT clears the grace bit
        @(negedge clk);
        drive(5'b11000, 4'd15);
        #1;
        check("R4", "hold id15", 32'(s2_hold_o), 1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", "s3 under reset", 32'(s3_update_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R12", "hold again after reset", 32'({s2_hold_o, replay_o, s2_advance_o}), 32'(3'b100));
        @(negedge clk);
        #1;
        check("R6", "replay after grace", 32'({s2_hold_o, replay_o, s2_advance_o}), 32'(3'b010));
        check("R8", "replay id max", 32'(replay_id_o), 15);
        check("R8", "replay vec max", 32'(replay_vec_o), 32'h8000);
        @(negedge clk);
        drive(5'b00000, 4'd0);
        #1;
        check("R9", "no s3 after replay", 32'({s3_update_o, refill_done_o, wb_req_o}), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule